// File: doc/BRIEF.md
# Predicate Bitmap Packer

This block turns a vector predicate into a dense bitmap and places that bitmap inside a vector value. The predicate holds one element for every lane of the chosen element size. Each element is `esize/8` bits wide, and only its lowest bit counts. The block gathers those lowest bits into a run of `VL/esize` bits. A block index chooses which `VL/esize`-bit slot of the vector receives the run.

The index also chooses what happens to the rest of the vector:

- **Index zero:** every bit outside the run is cleared.
- **Index other than zero:** the previous destination value passes through, and only the selected slot is overwritten.

Each element size allows only a certain range of index values. A request whose index falls outside that range is flagged in the same cycle and is dropped.

Requests enter as a single-cycle `in_valid` strobe. The merged vector is registered and appears one clock later, together with a one-cycle `out_valid`. The vector length `VL_BITS` is a parameter.

Top module: `pbp_pack`

## Requirements
- R1: Element-size codes on `esz_sel` are 00 for 8-bit, 01 for 16-bit, 10 for 32-bit and 11 for 64-bit. Packed bit e is taken from `pred[e*esize/8]`, which is the lowest bit of predicate element e. A 1 marks an active element and a 0 an inactive one.
- R2: Exactly `VL/esize` packed bits are produced. They land at result bits `idx*(VL/esize)` through `idx*(VL/esize)+VL/esize-1`.
- R3: When `blk_idx` is 0, every result bit outside the packed run is 0, including bits `VL-1` down to `VL/8`.
- R4: When `blk_idx` is not 0, every result bit outside the selected slot equals the corresponding bit of `dest_old`.
- R5: The allowed index range depends on the size: 0 only for 8-bit, 0 to 1 for 16-bit, 0 to 3 for 32-bit and 0 to 7 for 64-bit. `idx_illegal` is high in the same cycle exactly when `in_valid` is high and the index is out of range.
- R6: A request flagged illegal leaves `res_q` unchanged and produces no `out_valid` pulse.
- R7: A legal request is captured at the clock edge where `in_valid` is high. In the next cycle `out_valid` is high for one cycle and `res_q` holds the merged vector.
- R8: While `in_valid` is low, `res_q` holds its value and `out_valid` is low.
- R9: A synchronous, active-low reset clears `res_q` and `out_valid`.
- R10: `VL_BITS` must be a positive multiple of 128. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| pred | input | VL_BITS/8 | Source predicate |
| esz_sel | input | 2 | Element-size code |
| blk_idx | input | 3 | Destination slot index |
| dest_old | input | VL_BITS | Previous destination vector |
| idx_illegal | output | 1 | Request index out of range for the size |
| res_q | output | VL_BITS | Registered merged vector |
| out_valid | output | 1 | Result strobe, one cycle after a legal request |

## Verification
On every cycle the assertions check the control behaviour:

- the same-cycle illegal flag for the 8-bit and 64-bit sizes;
- the one-cycle valid pulse;
- holding of the result when nothing legal arrives;
- the contents of the bits above the low eighth of the vector, which are cleared when the index is zero and kept when it is not.

Only the bench scenarios can show the remaining behaviour, because checking it needs a full model of the bit gather and the slot insert. That covers:

- which predicate bit lands at which result position, for every size and index pair;
- the preservation of the unselected slots inside the low eighth;
- the agreement of two vector lengths, 256 and 128, under all-ones, all-zeros and random predicates.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE = 2'd0,
      ESZ_HALF = 2'd1,
      ESZ_WORD = 2'd2,
      ESZ_DBL  = 2'd3
   } esz_e;

   localparam int unsigned NUM_SIZES = 4;
   localparam int unsigned IDX_W     = 3;

   // number of slots available for size code s
   function automatic int unsigned slots_for(input int unsigned s);
      return 32'd1 << s;
   endfunction

endpackage

// File: rtl/pbp_gather.sv
module pbp_gather
   import pbp_pkg::*;
#(
   parameter int unsigned VL_BITS = 256
) (
   input  esz_e                   esz,
   input  logic [VL_BITS/8-1:0]   pred,
   output logic [VL_BITS/8-1:0]   bitmap
);
   localparam int unsigned PW = VL_BITS / 8;

   logic [NUM_SIZES-1:0][PW-1:0] cand;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int unsigned STRIDE = 1 << s;
      localparam int unsigned NBITS  = PW >> s;
      for (genvar e = 0; e < NBITS; e++) begin : g_elem
         assign cand[s][e] = pred[e*STRIDE];
      end
      if (NBITS < PW) begin : g_pad
         assign cand[s][PW-1:NBITS] = '0;
      end
   end

   always_comb bitmap = cand[esz];

endmodule

// File: rtl/pbp_range_chk.sv
module pbp_range_chk
   import pbp_pkg::*;
(
   input  esz_e             esz,
   input  logic [IDX_W-1:0] idx,
   output logic             legal
);
   logic [IDX_W:0] limit;

   always_comb begin
      limit = (IDX_W+1)'(1) << esz;
      legal = ({1'b0, idx} < limit);
   end

endmodule

// File: rtl/pbp_merge.sv
module pbp_merge
   import pbp_pkg::*;
#(
   parameter int unsigned VL_BITS = 256
) (
   input  esz_e                 esz,
   input  logic [IDX_W-1:0]     idx,
   input  logic [VL_BITS/8-1:0] bitmap,
   input  logic [VL_BITS-1:0]   dest_old,
   output logic [VL_BITS-1:0]   merged
);
   localparam int unsigned PW = VL_BITS / 8;

   logic                          keep_old;
   logic [PW-1:0]                 base_lo;
   logic [NUM_SIZES-1:0][PW-1:0]  cand;

   assign keep_old = (idx != '0);
   assign base_lo  = keep_old ? dest_old[PW-1:0] : '0;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int unsigned NSLOT = slots_for(s);
      localparam int unsigned SW    = PW >> s;
      for (genvar b = 0; b < NSLOT; b++) begin : g_slot
         assign cand[s][b*SW +: SW] = (idx == IDX_W'(b)) ? bitmap[SW-1:0]
                                                         : base_lo[b*SW +: SW];
      end
   end

   always_comb begin
      merged[PW-1:0]         = cand[esz];
      merged[VL_BITS-1:PW]   = keep_old ? dest_old[VL_BITS-1:PW] : '0;
   end

endmodule

// File: rtl/pbp_pack.sv
module pbp_pack
   import pbp_pkg::*;
#(
   parameter int unsigned VL_BITS = 256
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [VL_BITS/8-1:0]   pred,
   input  logic [1:0]             esz_sel,
   input  logic [2:0]             blk_idx,
   input  logic [VL_BITS-1:0]     dest_old,
   output logic                   idx_illegal,
   output logic [VL_BITS-1:0]     res_q,
   output logic                   out_valid
);
   localparam int unsigned PW = VL_BITS / 8;

   // R10: vector length must be a positive multiple of 128
   if (VL_BITS < 128 || (VL_BITS % 128) != 0) begin : g_bad_vl
      $error("pbp_pack: VL_BITS must be a positive multiple of 128");
   end

   esz_e            esz_t;
   logic            legal;
   logic [PW-1:0]   bitmap;
   logic [VL_BITS-1:0] merged;

   assign esz_t = esz_e'(esz_sel);

   pbp_gather #(.VL_BITS(VL_BITS)) gather_i (
      .esz    (esz_t),
      .pred   (pred),
      .bitmap (bitmap)
   );

   pbp_range_chk range_i (
      .esz   (esz_t),
      .idx   (blk_idx),
      .legal (legal)
   );

   pbp_merge #(.VL_BITS(VL_BITS)) merge_i (
      .esz      (esz_t),
      .idx      (blk_idx),
      .bitmap   (bitmap),
      .dest_old (dest_old),
      .merged   (merged)
   );

   assign idx_illegal = in_valid & ~legal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q     <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid & legal;
         if (in_valid && legal) begin
            res_q <= merged;
         end
      end
   end

endmodule

// File: rtl/pbp_chk.sv
module pbp_chk #(
   parameter int unsigned VL_BITS = 256
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [1:0]           esz_sel,
   input logic [2:0]           blk_idx,
   input logic [VL_BITS-1:0]   dest_old,
   input logic                 idx_illegal,
   input logic [VL_BITS-1:0]   res_q,
   input logic                 out_valid
);
   localparam int unsigned PW = VL_BITS / 8;

   // R5
   byte_idx_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && esz_sel == 2'b00 && blk_idx != 3'd0) |-> idx_illegal);

   // R5
   dbl_idx_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && esz_sel == 2'b11) |-> !idx_illegal);

   // R5
   illegal_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_illegal |-> in_valid);

   // R6
   illegal_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_illegal |=> ($stable(res_q) && !out_valid));

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !idx_illegal) |=> out_valid);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res_q) && !out_valid));

   // R3
   upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !idx_illegal && blk_idx == 3'd0) |=> (res_q[VL_BITS-1:PW] == '0));

   // R4
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !idx_illegal && blk_idx != 3'd0)
      |=> (res_q[VL_BITS-1:PW] == $past(dest_old[VL_BITS-1:PW])));

endmodule

bind pbp_pack pbp_chk #(.VL_BITS(VL_BITS)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .esz_sel     (esz_sel),
   .blk_idx     (blk_idx),
   .dest_old    (dest_old),
   .idx_illegal (idx_illegal),
   .res_q       (res_q),
   .out_valid   (out_valid)
);

// File: tb/pbp_pack_tb_top.sv
module pbp_pack_tb_top;
   localparam int VLA = 256;
   localparam int VLB = 128;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [31:0]    pred = '0;
   logic [1:0]     esz_sel = '0;
   logic [2:0]     blk_idx = '0;
   logic [255:0]   dest_old = '0;
   logic           ill_a, ill_b, ov_a, ov_b;
   logic [255:0]   res_a;
   logic [127:0]   res_b;

   logic [255:0]   exp_a = '0;
   logic [255:0]   exp_b = '0;
   int             checks = 0;
   int             errors = 0;
   bit             done = 1'b0;

   always #5 clk = ~clk;

   pbp_pack #(.VL_BITS(VLA)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pred(pred),
      .esz_sel(esz_sel), .blk_idx(blk_idx), .dest_old(dest_old),
      .idx_illegal(ill_a), .res_q(res_a), .out_valid(ov_a));

   pbp_pack #(.VL_BITS(VLB)) dut_s_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pred(pred[15:0]),
      .esz_sel(esz_sel), .blk_idx(blk_idx), .dest_old(dest_old[127:0]),
      .idx_illegal(ill_b), .res_q(res_b), .out_valid(ov_b));

   function automatic logic [255:0] model(input int vl, input logic [255:0] old,
                                          input logic [31:0] pr, input int s, input int idx);
      logic [255:0] r;
      int stride = 1 << s;
      int n = vl / (8 * stride);
      r = '0;
      if (idx != 0) begin
         for (int i = 0; i < vl; i++) r[i] = old[i];
      end
      for (int e = 0; e < n; e++) r[n*idx+e] = pr[e*stride];
      return r;
   endfunction

   function automatic logic [255:0] rand256();
      logic [255:0] v;
      for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [255:0] act, input logic [255:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic check_outputs(input bit vexp, input string tag);
      chk(ov_a == vexp, {tag, " valid VL256"}, 256'(ov_a), 256'(vexp));
      chk(ov_b == vexp, {tag, " valid VL128"}, 256'(ov_b), 256'(vexp));
      chk(res_a == exp_a, {tag, " data VL256"}, res_a, exp_a);
      chk({128'b0, res_b} == exp_b, {tag, " data VL128"}, {128'b0, res_b}, exp_b);
   endtask

   // one request followed by an idle cycle
   task automatic do_op(input logic [31:0] pr, input logic [255:0] old,
                        input int s, input int idx);
      bit legal;
      string tag;
      legal = (idx < (1 << s));
      @(negedge clk);
      pred = pr; dest_old = old; esz_sel = 2'(s); blk_idx = 3'(idx); in_valid = 1'b1;
      #1;
      chk(ill_a == !legal, "R5 flag VL256", 256'(ill_a), 256'(!legal));
      chk(ill_b == !legal, "R5 flag VL128", 256'(ill_b), 256'(!legal));
      @(negedge clk);
      in_valid = 1'b0;
      if (legal) begin
         exp_a = model(VLA, old, pr, s, idx);
         exp_b = model(VLB, old, pr, s, idx);
         tag = (idx == 0) ? "R1 R2 R3 R7" : "R1 R2 R4 R7";
      end else begin
         tag = "R6";
      end
      check_outputs(legal, tag);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(res_a == '0 && res_b == '0, "R9 reset data", res_a, '0);
      chk(!ov_a && !ov_b, "R9 reset valid", 256'(ov_a | ov_b), '0);
      exp_a = '0; exp_b = '0;
   endtask

   task automatic t_sweep();
      for (int p = 0; p < 3; p++) begin
         for (int s = 0; s < 4; s++) begin
            for (int idx = 0; idx < 8; idx++) begin
               logic [31:0] pr;
               pr = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 : $urandom();
               do_op(pr, rand256(), s, idx);
            end
         end
      end
   endtask

   task automatic t_idle();
      @(negedge clk);
      pred = $urandom(); dest_old = rand256(); blk_idx = 3'd1; esz_sel = 2'd3;
      repeat (4) begin
         @(negedge clk);
         check_outputs(1'b0, "R8 idle");
      end
   endtask

   task automatic t_back2back();
      logic [31:0]  p1, p2;
      logic [255:0] o1, o2;
      p1 = $urandom(); p2 = $urandom(); o1 = rand256(); o2 = rand256();
      @(negedge clk);
      pred = p1; dest_old = o1; esz_sel = 2'd2; blk_idx = 3'd3; in_valid = 1'b1;
      @(negedge clk);
      exp_a = model(VLA, o1, p1, 2, 3); exp_b = model(VLB, o1, p1, 2, 3);
      check_outputs(1'b1, "R7 R4 first of pair");
      pred = p2; dest_old = o2; esz_sel = 2'd1; blk_idx = 3'd0;
      @(negedge clk);
      in_valid = 1'b0;
      exp_a = model(VLA, o2, p2, 1, 0); exp_b = model(VLB, o2, p2, 1, 0);
      check_outputs(1'b1, "R7 R3 second of pair");
   endtask

   task automatic t_reset_mid();
      do_op(32'hA5A5_5A5A, rand256(), 3, 5);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      exp_a = '0; exp_b = '0;
      check_outputs(1'b0, "R9 reset after data");
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_sweep();
      t_idle();
      t_back2back();
      t_reset_mid();
      do_op(32'h0000_0001, rand256(), 0, 0);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule